// File: doc/BRIEF.md
# Condition and Exception Flag Unit

This unit keeps the status state of a 32-bit integer datapath. Each cycle it can take one retiring ALU operation (its result, carry-out and signed-overflow indication, plus the per-operation record and overflow-enable controls). From these it updates a 32-bit condition register and a three-flag exception register. The condition register is split into eight 4-bit fields. Field 0 is the record target for ALU results. Any field, or any single condition bit, can also be written directly by move or condition-logic operations.

The exception register holds overflow, a sticky summary overflow and carry. The carry flag is driven out at all times so that add-extended operations can use it as an addend. Bits use big-endian numbering: bit 0 is the MSB of the condition register, so field n covers bits 4n to 4n+3. All state is registered, and every update shows on the outputs after the clock edge that takes it.

Top module: `cond_flag_unit`

## Requirements
- R1: After reset the condition register and all three exception flags read 0.
- R2: Condition bit k is output bit `cr_out[31-k]`, and field n covers bits 4n..4n+3. When a recorded operation has `op_valid=1` and `op_rc=1`, field 0 takes the following values: less-than (`cr_out[31]`) is the result sign, greater-than (`cr_out[30]`) is set for a positive non-zero result, and equal (`cr_out[29]`) is set for a zero result.
- R3: The summary-overflow bit of field 0 (`cr_out[28]`) is recorded as the exception summary overflow held before the operation, ORed with `op_ovf` when `op_oe=1`.
- R4: With `op_rc=0`, or with no valid operation and no explicit write, the condition register is unchanged.
- R5: A valid operation with `op_oe=1` loads overflow from `op_ovf` and ORs `op_ovf` into summary overflow. With `op_oe=0`, neither flag changes.
- R6: Summary overflow is sticky. Once set, it is cleared only by an explicit exception-register write.
- R7: A valid operation with `op_ca_we=1` loads carry from `op_carry`. Otherwise carry holds, and it is always visible on `xer_ca`.
- R8: `crf_we=1` loads `crf_data` into field `crf_sel`. Data bit 3 goes to less-than and data bit 0 goes to summary-overflow.
- R9: `crb_we=1` writes `crb_data` into condition bit `crb_sel`, which is `cr_out[31-crb_sel]`.
- R10: Explicit writes have priority. A field write overrides a field-0 record in the same cycle, and a bit write overrides both. `xer_we=1` loads `xer_wdata` as {overflow, summary overflow, carry} (bit 2 down to bit 0) and overrides any flag update from an operation in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An ALU operation retires this cycle |
| op_rc | input | 1 | Record result flags into field 0 |
| op_oe | input | 1 | Record overflow into the exception register |
| op_ca_we | input | 1 | The operation writes carry |
| op_result | input | 32 | ALU result |
| op_carry | input | 1 | ALU carry-out |
| op_ovf | input | 1 | ALU signed overflow |
| crf_we | input | 1 | Whole-field write enable |
| crf_sel | input | 3 | Field number for the field write |
| crf_data | input | 4 | Field value {LT,GT,EQ,SO} |
| crb_we | input | 1 | Single-bit write enable |
| crb_sel | input | 5 | Condition bit number (0 = MSB) |
| crb_data | input | 1 | Value for the single bit |
| xer_we | input | 1 | Explicit exception-register write |
| xer_wdata | input | 3 | {OV, SO, CA} to load |
| cr_out | output | 32 | Condition register |
| xer_ov | output | 1 | Overflow flag |
| xer_so | output | 1 | Summary overflow flag |
| xer_ca | output | 1 | Carry flag, fed to add-extended operations |

## Verification
Every input combination, whether a record, an overflow update, a field write, a bit write or an exception write, takes effect at the first rising edge after it is driven. All four outputs are therefore due exactly one edge later. The driver applies each stimulus on a falling edge and pushes the expected register image into a queue. The monitor pops and compares that image 5 ns after the next rising edge, so each stimulus is checked once, at its own due cycle.

// File: rtl/cfu_pkg.sv
package cfu_pkg;
    localparam int unsigned NIB_W = 4;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } crnib_t;

    typedef struct packed {
        logic ov;
        logic so;
        logic ca;
    } xflags_t;
endpackage

// File: rtl/cfu_flag_derive.sv
module cfu_flag_derive
    import cfu_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] result,
    input  logic              ovf,
    input  logic              oe,
    input  logic              so_now,
    output crnib_t            nib
);
    logic is_zero;

    always_comb begin
        is_zero = (result == '0);
        nib.lt  = result[DATA_W-1];
        nib.gt  = !result[DATA_W-1] && !is_zero;
        nib.eq  = is_zero;
        nib.so  = so_now | (oe & ovf);
    end
endmodule

// File: rtl/cfu_xer_reg.sv
module cfu_xer_reg
    import cfu_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    upd_en,
    input  logic    oe,
    input  logic    ovf,
    input  logic    ca_we,
    input  logic    carry,
    input  logic    sw_we,
    input  xflags_t sw_data,
    output xflags_t q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (sw_we) begin
            q <= sw_data;
        end else if (upd_en) begin
            if (oe) begin
                q.ov <= ovf;
                q.so <= q.so | ovf;
            end
            if (ca_we) begin
                q.ca <= carry;
            end
        end
    end

    AST_SO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.so && !sw_we) |=> q.so); // R6
    AST_OV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(upd_en && oe) && !sw_we) |=> $stable(q.ov)); // R5
    AST_CA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(upd_en && ca_we) && !sw_we) |=> $stable(q.ca)); // R7
    AST_XER_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we |=> (q == $past(sw_data))); // R10
endmodule

// File: rtl/cfu_cr_reg.sv
module cfu_cr_reg
    import cfu_pkg::*;
#(
    parameter int unsigned NUM_FIELDS = 8,
    localparam int unsigned CR_W   = NUM_FIELDS * NIB_W,
    localparam int unsigned FSEL_W = $clog2(NUM_FIELDS),
    localparam int unsigned BSEL_W = $clog2(CR_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rec_en,
    input  crnib_t            rec_nib,
    input  logic              fld_we,
    input  logic [FSEL_W-1:0] fld_sel,
    input  logic [NIB_W-1:0]  fld_data,
    input  logic              bit_we,
    input  logic [BSEL_W-1:0] bit_sel,
    input  logic              bit_data,
    output logic [CR_W-1:0]   cr_q
);
    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        localparam int unsigned TOP = CR_W - 1 - NIB_W * f;
        logic [NIB_W-1:0] q;
        logic [NIB_W-1:0] d;

        always_comb begin
            d = q;
            if ((f == 0) && rec_en) begin
                d = rec_nib;
            end
            if (fld_we && (fld_sel == FSEL_W'(f))) begin
                d = fld_data;
            end
            for (int b = 0; b < NIB_W; b++) begin
                if (bit_we && (bit_sel == BSEL_W'(NIB_W * f + b))) begin
                    d[NIB_W-1-b] = bit_data;
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else begin
                q <= d;
            end
        end

        assign cr_q[TOP -: NIB_W] = q;
    end

    AST_CR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rec_en && !fld_we && !bit_we) |=> $stable(cr_q)); // R4
    AST_CR0_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_en && !fld_we && !bit_we) |=> ($countones(cr_q[CR_W-1 -: 3]) == 1)); // R2
    AST_BIT_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        bit_we |=> (cr_q[CR_W-1-int'($past(bit_sel))] == $past(bit_data))); // R9
endmodule

// File: rtl/cond_flag_unit.sv
module cond_flag_unit
    import cfu_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned NUM_FIELDS = 8,
    localparam int unsigned CR_W   = NUM_FIELDS * NIB_W,
    localparam int unsigned FSEL_W = $clog2(NUM_FIELDS),
    localparam int unsigned BSEL_W = $clog2(CR_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              op_rc,
    input  logic              op_oe,
    input  logic              op_ca_we,
    input  logic [DATA_W-1:0] op_result,
    input  logic              op_carry,
    input  logic              op_ovf,
    input  logic              crf_we,
    input  logic [FSEL_W-1:0] crf_sel,
    input  logic [NIB_W-1:0]  crf_data,
    input  logic              crb_we,
    input  logic [BSEL_W-1:0] crb_sel,
    input  logic              crb_data,
    input  logic              xer_we,
    input  logic [2:0]        xer_wdata,
    output logic [CR_W-1:0]   cr_out,
    output logic              xer_ov,
    output logic              xer_so,
    output logic              xer_ca
);
    xflags_t xq;
    xflags_t xw;
    crnib_t  rec_nib;

    assign xw = xer_wdata;

    cfu_flag_derive #(.DATA_W(DATA_W)) u_derive (
        .result (op_result),
        .ovf    (op_ovf),
        .oe     (op_oe),
        .so_now (xq.so),
        .nib    (rec_nib)
    );

    cfu_xer_reg u_xer (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_en  (op_valid),
        .oe      (op_oe),
        .ovf     (op_ovf),
        .ca_we   (op_ca_we),
        .carry   (op_carry),
        .sw_we   (xer_we),
        .sw_data (xw),
        .q       (xq)
    );

    cfu_cr_reg #(.NUM_FIELDS(NUM_FIELDS)) u_cr (
        .clk      (clk),
        .rst_n    (rst_n),
        .rec_en   (op_valid && op_rc),
        .rec_nib  (rec_nib),
        .fld_we   (crf_we),
        .fld_sel  (crf_sel),
        .fld_data (crf_data),
        .bit_we   (crb_we),
        .bit_sel  (crb_sel),
        .bit_data (crb_data),
        .cr_q     (cr_out)
    );

    assign xer_ov = xq.ov;
    assign xer_so = xq.so;
    assign xer_ca = xq.ca;

    AST_SO_FROM_OV: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_oe && op_ovf && !xer_we) |=> (xer_so && xer_ov)); // R5
    AST_CR0_SO_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_rc && xer_so && !crf_we && !crb_we) |=> cr_out[CR_W-NIB_W]); // R3
endmodule

// File: tb/cond_flag_unit_tb.sv
module cond_flag_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid, op_rc, op_oe, op_ca_we, op_carry, op_ovf;
    logic [31:0] op_result;
    logic        crf_we, crb_we, crb_data, xer_we;
    logic [2:0]  crf_sel, xer_wdata;
    logic [3:0]  crf_data;
    logic [4:0]  crb_sel;
    logic [31:0] cr_out;
    logic        xer_ov, xer_so, xer_ca;

    typedef struct {
        logic [31:0] cr;
        logic        ov;
        logic        so;
        logic        ca;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;
    logic [31:0] m_cr = '0;
    logic        m_ov = 1'b0, m_so = 1'b0, m_ca = 1'b0;

    always #10 clk = ~clk;

    cond_flag_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_rc(op_rc), .op_oe(op_oe),
        .op_ca_we(op_ca_we), .op_result(op_result), .op_carry(op_carry), .op_ovf(op_ovf),
        .crf_we(crf_we), .crf_sel(crf_sel), .crf_data(crf_data), .crb_we(crb_we),
        .crb_sel(crb_sel), .crb_data(crb_data), .xer_we(xer_we), .xer_wdata(xer_wdata),
        .cr_out(cr_out), .xer_ov(xer_ov), .xer_so(xer_so), .xer_ca(xer_ca)
    );

    task automatic clear_inputs();
        op_valid = 0; op_rc = 0; op_oe = 0; op_ca_we = 0; op_carry = 0; op_ovf = 0;
        op_result = '0; crf_we = 0; crf_sel = '0; crf_data = '0; crb_we = 0;
        crb_sel = '0; crb_data = 0; xer_we = 0; xer_wdata = '0;
    endtask

    task automatic begin_cycle();
        @(negedge clk);
        clear_inputs();
    endtask

    // Driver side: expected state from the requirements, pushed to the scoreboard.
    task automatic push(input string tag);
        exp_t        e;
        logic [31:0] n;
        n = m_cr;
        if (op_valid && op_rc) begin
            n[31] = op_result[31];
            n[30] = !op_result[31] && (op_result != 0);
            n[29] = (op_result == 0);
            n[28] = m_so | (op_oe & op_ovf);
        end
        if (crf_we) n[31 - 4*int'(crf_sel) -: 4] = crf_data;
        if (crb_we) n[31 - int'(crb_sel)] = crb_data;
        if (xer_we) begin
            {m_ov, m_so, m_ca} = xer_wdata;
        end else if (op_valid) begin
            if (op_oe) begin
                m_ov = op_ovf;
                m_so = m_so | op_ovf;
            end
            if (op_ca_we) m_ca = op_carry;
        end
        m_cr = n;
        e.cr = m_cr; e.ov = m_ov; e.so = m_so; e.ca = m_ca; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: one stimulus is due at the rising edge after it was driven.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                total++;
                if (cr_out !== e.cr || xer_ov !== e.ov || xer_so !== e.so || xer_ca !== e.ca) begin
                    bad++;
                    $display("FAIL %s: cr=%h ov=%b so=%b ca=%b expected cr=%h ov=%b so=%b ca=%b",
                             e.tag, cr_out, xer_ov, xer_so, xer_ca, e.cr, e.ov, e.so, e.ca);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        clear_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        begin_cycle(); push("R1 reset state");

        begin_cycle(); op_valid = 1; op_rc = 1; op_result = 32'h8000_0005; push("R2 negative");
        begin_cycle(); op_valid = 1; op_rc = 1; op_result = 32'h0000_0007; push("R2 positive");
        begin_cycle(); op_valid = 1; op_rc = 1; op_result = 32'h0000_0000; push("R2 zero");
        begin_cycle(); op_valid = 1; op_rc = 0; op_result = 32'h0000_0005; push("R4 no record");
        begin_cycle(); push("R4 idle hold");

        begin_cycle(); op_valid = 1; op_rc = 0; op_oe = 0; op_ovf = 1; push("R5 oe off");
        begin_cycle(); op_valid = 1; op_rc = 1; op_oe = 0; op_ovf = 1;
                       op_result = 32'h0000_0003; push("R3 so clear oe off");
        begin_cycle(); op_valid = 1; op_rc = 1; op_oe = 1; op_ovf = 1;
                       op_result = 32'h7FFF_FFFF; push("R3 R5 overflow recorded");
        begin_cycle(); op_valid = 1; op_rc = 1; op_oe = 1; op_ovf = 0;
                       op_result = 32'h0000_0001; push("R6 so sticky");
        begin_cycle(); op_valid = 1; op_rc = 0; op_oe = 1; op_ovf = 0; push("R6 so still set");

        begin_cycle(); op_valid = 1; op_ca_we = 1; op_carry = 1; push("R7 carry load");
        begin_cycle(); op_valid = 1; op_ca_we = 0; op_carry = 0; push("R7 carry hold");
        begin_cycle(); op_valid = 1; op_ca_we = 1; op_carry = 0; push("R7 carry clear");

        begin_cycle(); xer_we = 1; xer_wdata = 3'b001; push("R6 explicit clear");
        begin_cycle(); op_valid = 1; op_rc = 1; op_result = 32'hFFFF_FFFF; push("R3 so after clear");

        begin_cycle(); crf_we = 1; crf_sel = 3'd5; crf_data = 4'b1010; push("R8 field 5");
        begin_cycle(); crf_we = 1; crf_sel = 3'd7; crf_data = 4'b0001; push("R8 field 7");
        begin_cycle(); crb_we = 1; crb_sel = 5'd31; crb_data = 0; push("R9 bit 31");
        begin_cycle(); crb_we = 1; crb_sel = 5'd9; crb_data = 1; push("R9 bit 9");
        begin_cycle(); crb_we = 1; crb_sel = 5'd0; crb_data = 0; push("R9 bit 0");

        begin_cycle(); op_valid = 1; op_rc = 1; op_result = 32'h0000_0000;
                       crf_we = 1; crf_sel = 3'd0; crf_data = 4'b0110; push("R10 field over record");
        begin_cycle(); crf_we = 1; crf_sel = 3'd2; crf_data = 4'b0000;
                       crb_we = 1; crb_sel = 5'd10; crb_data = 1; push("R10 bit over field");
        begin_cycle(); op_valid = 1; op_rc = 1; op_result = 32'h0000_0004;
                       crb_we = 1; crb_sel = 5'd2; crb_data = 1; push("R10 bit over record");
        begin_cycle(); op_valid = 1; op_oe = 1; op_ovf = 1; op_ca_we = 1; op_carry = 1;
                       xer_we = 1; xer_wdata = 3'b000; push("R10 xer write wins");
        begin_cycle(); xer_we = 1; xer_wdata = 3'b110; push("R10 xer load");

        begin_cycle();
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule